// File: doc/BRIEF.md
# Event-Driven Leaky Integrate-and-Fire Neuron

This block holds one spiking neuron's membrane potential as a signed Q8.8 fixed-point number: 16 bits in two's complement, with 8 integer and 8 fractional bits. The state changes only in a cycle that carries a synaptic event, a leak tick, or both. An event adds its signed Q8.8 weight to the potential. A leak tick subtracts a configured leak amount. After the update the result is compared with a configured threshold. If the threshold is reached, a spike is emitted and the potential is loaded with a configured reset value.

In every other cycle the state register's enable stays low, so an idle neuron draws no switching activity. An upstream serializer delivers at most one synaptic event per cycle. A separate timer supplies the leak ticks. The spike output feeds whatever fan-out logic follows. The current potential is also driven out, so that the neuron can be monitored.

Top module: `lif_event_neuron`

## Requirements
- R1: While the synchronous reset `rst` is high at a clock edge, the potential becomes 0 and `spike` becomes 0 from the next cycle, and this takes precedence over any event or tick in the same cycle.
- R2: At an edge where `evtValid` is 1 and `leakTick` is 0, the signed 16-bit weight `evtWeight` is added to the potential.
- R3: At an edge where `leakTick` is 1 and `evtValid` is 0, `cfgLeak` is subtracted from the potential.
- R4: When an event and a leak tick arrive in the same cycle, the leak is subtracted first and the weight is added to that intermediate result. Each step saturates separately.
- R5: Every addition and subtraction saturates at the signed 16-bit limits, 16'sh7FFF and 16'sh8000, and never wraps.
- R6: When the updated value is signed greater than or equal to `cfgThresh`, `spike` is 1 in the next cycle and the potential equals the `cfgReset` value sampled at that edge. Otherwise the updated value is stored and `spike` is 0.
- R7: In a cycle with neither an event nor a leak tick, the potential keeps its value and `spike` is 0, whatever the weight and configuration inputs are.
- R8: `spike` is high for one cycle per firing update. It returns to 0 after any cycle that does not fire.
- R9: Asserting reset at the edge where an update would fire suppresses that spike.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| evtValid | input | 1 | A synaptic event is present this cycle |
| evtWeight | input | 16 | Signed Q8.8 weight of the event |
| leakTick | input | 1 | Periodic leak strobe |
| cfgThresh | input | 16 | Signed Q8.8 firing threshold |
| cfgLeak | input | 16 | Signed Q8.8 amount subtracted per tick |
| cfgReset | input | 16 | Signed Q8.8 potential loaded after a spike |
| spike | output | 1 | One-cycle spike pulse |
| membrane | output | 16 | Current signed Q8.8 potential |

## Verification
The neuron is driven through:
- idle stretches with a changing weight bus, which separate gated updates from free-running ones;
- runs of positive and negative weights alone, and leak ticks alone, which confirm the sign and direction of each operation;
- a coincident tick and event near the negative limit, where leak-then-add and add-then-leak saturate to different values;
- drives deep into the negative limit, which show saturation rather than wrap;
- a firing event with reset held high at the same edge;
- a long random mix of events, ticks and weights against a small threshold, which exercises repeated firing and reset loading.

// File: rtl/lif_pkg.sv
package lif_pkg;

  // Control-to-datapath strobes for one neuron update.
  typedef struct packed {
    logic leakEn;   // apply leak subtraction in this update
    logic addEn;    // apply event weight addition
    logic stateEn;  // potential register enable
    logic spikeEn;  // spike register enable
  } lif_strobe_t;

endpackage

// File: rtl/lif_sat_addsub.sv
module lif_sat_addsub #(
  parameter int W = 16
) (
  input  logic signed [W-1:0] opA,
  input  logic signed [W-1:0] opB,
  input  logic                doSub,
  output logic signed [W-1:0] result
);
  localparam int EW = W + 1;
  localparam logic signed [W-1:0] MAX_V = {1'b0, {(W-1){1'b1}}};
  localparam logic signed [W-1:0] MIN_V = {1'b1, {(W-1){1'b0}}};

  logic signed [EW-1:0] extA;
  logic signed [EW-1:0] extB;
  logic signed [EW-1:0] extSum;

  always_comb begin
    extA   = {opA[W-1], opA};
    extB   = {opB[W-1], opB};
    extSum = doSub ? (extA - extB) : (extA + extB);
    if (extSum[EW-1] != extSum[EW-2]) begin
      result = extSum[EW-1] ? MIN_V : MAX_V;
    end else begin
      result = extSum[W-1:0];
    end
  end
endmodule

// File: rtl/lif_ctrl.sv
module lif_ctrl
  import lif_pkg::*;
(
  input  logic        evtValid,
  input  logic        leakTick,
  input  logic        spikeQ,
  output lif_strobe_t strobe
);
  always_comb begin
    strobe.leakEn  = leakTick;
    strobe.addEn   = evtValid;
    strobe.stateEn = evtValid | leakTick;
    // spike register only toggles on an update or to drop a pulse
    strobe.spikeEn = evtValid | leakTick | spikeQ;
  end
endmodule

// File: rtl/lif_datapath.sv
module lif_datapath
  import lif_pkg::*;
#(
  parameter int W = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  lif_strobe_t         strobe,
  input  logic signed [W-1:0] evtWeight,
  input  logic signed [W-1:0] cfgThresh,
  input  logic signed [W-1:0] cfgLeak,
  input  logic signed [W-1:0] cfgReset,
  output logic signed [W-1:0] potential,
  output logic                spikeQ
);
  logic signed [W-1:0] afterLeakRaw;
  logic signed [W-1:0] afterLeak;
  logic signed [W-1:0] afterAddRaw;
  logic signed [W-1:0] afterAdd;
  logic                fire;
  logic signed [W-1:0] nextPot;

  lif_sat_addsub #(.W(W)) uLeak (
    .opA(potential), .opB(cfgLeak), .doSub(1'b1), .result(afterLeakRaw)
  );

  assign afterLeak = strobe.leakEn ? afterLeakRaw : potential;

  lif_sat_addsub #(.W(W)) uAdd (
    .opA(afterLeak), .opB(evtWeight), .doSub(1'b0), .result(afterAddRaw)
  );

  assign afterAdd = strobe.addEn ? afterAddRaw : afterLeak;
  assign fire     = (afterAdd >= cfgThresh);
  assign nextPot  = fire ? cfgReset : afterAdd;

  always_ff @(posedge clk) begin
    if (rst) begin
      potential <= '0;
    end else if (strobe.stateEn) begin
      potential <= nextPot;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      spikeQ <= 1'b0;
    end else if (strobe.spikeEn) begin
      spikeQ <= strobe.stateEn & fire;
    end
  end

  // R1 / R9: reset clears state and any spike about to be emitted
  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> (potential == '0 && !spikeQ));

  // R7: idle cycles leave the potential alone and emit nothing
  a_r7_idle_hold: assert property (@(posedge clk) disable iff (rst)
    !strobe.stateEn |=> ($stable(potential) && !spikeQ));

  // R6: a spike is accompanied by the configured reset value
  a_r6_fire_reset: assert property (@(posedge clk) disable iff (rst)
    spikeQ |-> (potential == $past(cfgReset)));

  // R8: a spike only follows an update cycle
  a_r8_spike_cause: assert property (@(posedge clk) disable iff (rst)
    spikeQ |-> $past(strobe.stateEn));
endmodule

// File: rtl/lif_event_neuron.sv
module lif_event_neuron
  import lif_pkg::*;
#(
  parameter int W = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                evtValid,
  input  logic signed [W-1:0] evtWeight,
  input  logic                leakTick,
  input  logic signed [W-1:0] cfgThresh,
  input  logic signed [W-1:0] cfgLeak,
  input  logic signed [W-1:0] cfgReset,
  output logic                spike,
  output logic signed [W-1:0] membrane
);
  lif_strobe_t strobe;
  logic        spikeQ;

  lif_ctrl uCtrl (
    .evtValid(evtValid), .leakTick(leakTick), .spikeQ(spikeQ), .strobe(strobe)
  );

  lif_datapath #(.W(W)) uDp (
    .clk(clk), .rst(rst), .strobe(strobe), .evtWeight(evtWeight),
    .cfgThresh(cfgThresh), .cfgLeak(cfgLeak), .cfgReset(cfgReset),
    .potential(membrane), .spikeQ(spikeQ)
  );

  assign spike = spikeQ;
endmodule

// File: tb/tb_lif_event_neuron.sv
module tb_lif_event_neuron;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic evtValid = 1'b0;
  logic leakTick = 1'b0;
  logic signed [15:0] evtWeight = '0;
  logic signed [15:0] cfgThresh = 16'sh0400;
  logic signed [15:0] cfgLeak = 16'sh0010;
  logic signed [15:0] cfgReset = 16'sh0000;
  logic spike;
  logic signed [15:0] membrane;

  int vecCount = 0;
  int failCount = 0;
  int cycles = 0;
  string curReq = "R1";
  int mPot = 0;
  bit mSpk = 1'b0;

  always #10 clk = ~clk;

  lif_event_neuron dut (
    .clk(clk), .rst(rst), .evtValid(evtValid), .evtWeight(evtWeight),
    .leakTick(leakTick), .cfgThresh(cfgThresh), .cfgLeak(cfgLeak),
    .cfgReset(cfgReset), .spike(spike), .membrane(membrane)
  );

  function automatic int clamp16(int x);
    if (x > 32767) return 32767;
    if (x < -32768) return -32768;
    return x;
  endfunction

  // behavioural reference, updated on every edge
  always @(posedge clk) begin
    int t;
    if (rst) begin
      mPot = 0;
      mSpk = 1'b0;
    end else if (evtValid || leakTick) begin
      t = mPot;
      if (leakTick) t = clamp16(t - int'(cfgLeak));
      if (evtValid) t = clamp16(t + int'(evtWeight));
      if (t >= int'(cfgThresh)) begin
        mPot = int'(cfgReset);
        mSpk = 1'b1;
      end else begin
        mPot = t;
        mSpk = 1'b0;
      end
    end else begin
      mSpk = 1'b0;
    end
  end

  // per-clock comparison, away from the active edge
  always @(negedge clk) begin
    vecCount++;
    if (int'(membrane) != mPot || spike != mSpk) begin
      failCount++;
      $display("FAIL %s: membrane=%0d spike=%0b expected membrane=%0d spike=%0b",
               curReq, membrane, spike, mPot, mSpk);
    end
  end

  task automatic tick(input bit ev, input int w, input bit lk);
    @(negedge clk);
    evtValid  = ev;
    evtWeight = 16'(w);
    leakTick  = lk;
  endtask

  task automatic expectNow(input string req, input int expPot, input bit expSpk);
    @(posedge clk);
    #1;
    vecCount++;
    if (int'(membrane) != expPot || spike != expSpk) begin
      failCount++;
      $display("FAIL %s: membrane=%0d spike=%0b expected membrane=%0d spike=%0b",
               req, membrane, spike, expPot, expSpk);
    end
  endtask

  initial begin
    // R1: reset state
    curReq = "R1";
    tick(1'b1, 16'sh0100, 1'b1);
    expectNow("R1", 0, 1'b0);
    tick(1'b0, 0, 1'b0);
    rst = 1'b0;
    expectNow("R1", 0, 1'b0);

    // R7: idle with changing weight and config
    curReq = "R7";
    for (int i = 0; i < 5; i++) begin
      tick(1'b0, 16'sh1234 + i, 1'b0);
      cfgThresh = 16'sh0400 - 16'(i);
    end
    cfgThresh = 16'sh0400;
    expectNow("R7", 0, 1'b0);

    // R2: event accumulation
    curReq = "R2";
    tick(1'b1, 16'sh0100, 1'b0);
    tick(1'b1, 16'sh0100, 1'b0);
    tick(1'b1, -128, 1'b0);
    expectNow("R2", 384, 1'b0);

    // R3: leak ticks
    curReq = "R3";
    for (int i = 0; i < 3; i++) tick(1'b0, 16'sh7000, 1'b1);
    expectNow("R3", 336, 1'b0);

    // R6: crossing fires and loads the reset value
    curReq = "R6";
    cfgReset = -256;
    tick(1'b1, 16'sh0300, 1'b0);
    expectNow("R6", -256, 1'b1);

    // R8: pulse ends after one cycle
    curReq = "R8";
    tick(1'b0, 0, 1'b0);
    expectNow("R8", -256, 1'b0);

    // R5: negative saturation
    curReq = "R5";
    tick(1'b1, -28672, 1'b0);
    tick(1'b1, -28672, 1'b0);
    expectNow("R5", -32768, 1'b0);

    // R4: coincident leak and event near the lower limit
    curReq = "R4";
    cfgLeak = 16'sh0200;
    tick(1'b1, 16'sh0100, 1'b0);
    expectNow("R4", -32512, 1'b0);
    tick(1'b1, 16'sh0100, 1'b1);
    expectNow("R4", -32512, 1'b0);

    // R9: reset at a firing edge suppresses the spike
    curReq = "R9";
    tick(1'b0, 0, 1'b0);
    rst = 1'b1;
    tick(1'b0, 0, 1'b0);
    rst = 1'b0;
    cfgLeak = 16'sh0010;
    cfgReset = 16'sh0000;
    tick(1'b1, 16'sh0380, 1'b0);
    tick(1'b1, 16'sh0100, 1'b0);
    rst = 1'b1;
    expectNow("R9", 0, 1'b0);
    tick(1'b0, 0, 1'b0);
    rst = 1'b0;

    // R6: random mix, repeated firing
    curReq = "R6";
    cfgThresh = 16'sh0200;
    cfgReset = -64;
    for (int i = 0; i < 400; i++) begin
      tick(($urandom % 3) != 0, int'($urandom % 512) - 160, ($urandom % 4) == 0);
      if ((i % 97) == 0) cfgLeak = 16'($urandom % 64);
    end
    tick(1'b0, 0, 1'b0);
    repeat (3) @(negedge clk);

    $display("== %0d vectors applied, %0d miscompares ==", vecCount, failCount);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      failCount++;
      $display("FAIL watchdog: cycles=%0d expected below 20000", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", vecCount, failCount);
      $finish;
    end
  end
endmodule